// File: doc/BRIEF.md
# Fault-Injecting Synchronous SRAM

A small synchronous static memory, 16 words of 8 bits, with a separate data-in bus, a separate data-out bus, a 4-bit address, an active-low write strobe and an active-low read strobe. It sits in the place of a real memory so that a memory tester can be graded. A runtime fault-select input chooses at most one defect. The defect is overlaid on the internal write-data path, the data-out bus, the internal address path or the strobe decoding. The tester runs its data-bus, address-bus and cell tests against the model, and each defect it misses shows a gap in its test suite.

Every defect is combinational and lies on the path between the pins and the storage array. The array is written in a form that maps onto a block RAM with a registered read port. A read samples the array on the clock edge and shows the word on the data-out bus after that edge. All fault codes are decoded from the three widths, so a wider model keeps the same ordering of code groups.

Top module: `fault_sram`

## Requirements
- R1: After synchronous reset is released, with fault code 0, dout is 0x00 until the first read completes.
- R2: With fault code 0, a rising edge with we_n low stores din at addr. A rising edge with we_n high and oe_n low reads the word at addr, and that word appears on dout after the edge.
- R3: When an edge samples oe_n high, or we_n low, dout holds 0x00 after that edge (fault code 0).
- R4: Codes 1+k (k = 0..7) force written data bit k to 0. Codes 9+k force written data bit k to 1.
- R5: Codes 17+k force dout bit k to 0 and codes 25+k force dout bit k to 1, also while dout is idle at 0x00.
- R6: Codes 33+j (j = 0,1) force address bit j to 0 for both writes and reads. Codes 35+j force it to 1.
- R7: Codes 37+k (k = 0..6) short written data bits k and k+1. Both bits take the AND of the two.
- R8: Codes 44+k (k = 0..6) short dout bits k and k+1 as a wired AND.
- R9: Codes 51+j (j = 0..2) short address bits j and j+1 as a wired AND.
- R10: Code 54 stores din at addr on every edge, whatever the level of we_n. A read on the same edge returns the word held before that write.
- R11: Code 55 blocks every write, so the array keeps its contents.
- R12: Code 56 keeps dout at 0x00 while writes still take place.
- R13: Codes 57 to 63 behave exactly as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the read-valid state |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low; a read also needs we_n high |
| addr | input | 4 | Word address |
| din | input | 8 | Write data |
| fault_sel | input | 6 | Injected defect code, 0 for none |
| dout | output | 8 | Read data, 0x00 when no read completed |

## Verification
The hardest case to reach is a collision. Under the forced-write code a read and a write hit the same word on one edge, and under address faults several addresses alias onto a single cell. Either way the word returned depends on the history of writes, not on the last write alone. To get there, the stimulus first fills every word with a distinct value under fault code 0. Then, for each of the 64 codes in turn, it runs a write pass and a read pass over all addresses, and during the read pass it keeps driving fresh data on din. A reference array in the bench tracks which cell each access really reached.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  typedef enum logic [2:0] {
    T_NONE,
    T_DIN,
    T_DOUT,
    T_ADDR,
    T_CTL
  } tgt_e;

  typedef enum logic [1:0] {
    K_S0,
    K_S1,
    K_SHORT
  } kind_e;

  typedef struct packed {
    tgt_e       tgt;
    kind_e      kind;
    logic [7:0] idx;
  } fault_t;

  localparam logic [7:0] CTL_ALWAYS_WR = 8'd0;
  localparam logic [7:0] CTL_NEVER_WR  = 8'd1;
  localparam logic [7:0] CTL_NEVER_RD  = 8'd2;

  // first code of the control group
  function automatic int ctl_base(input int dw, input int aw, input int nsa);
    return 1 + 4 * dw + 2 * nsa + 2 * (dw - 1) + (aw - 1);
  endfunction

  function automatic int sel_width(input int dw, input int aw, input int nsa);
    return $clog2(ctl_base(dw, aw, nsa) + 3);
  endfunction

  function automatic fault_t decode_fault(input int code, input int dw,
                                          input int aw, input int nsa);
    fault_t r;
    int b_din0, b_din1, b_out0, b_out1, b_adr0, b_adr1;
    int b_dsh, b_osh, b_ash, b_ctl;
    b_din0 = 1;
    b_din1 = b_din0 + dw;
    b_out0 = b_din1 + dw;
    b_out1 = b_out0 + dw;
    b_adr0 = b_out1 + dw;
    b_adr1 = b_adr0 + nsa;
    b_dsh  = b_adr1 + nsa;
    b_osh  = b_dsh + dw - 1;
    b_ash  = b_osh + dw - 1;
    b_ctl  = b_ash + aw - 1;
    r.tgt  = T_NONE;
    r.kind = K_S0;
    r.idx  = '0;
    if (code >= b_din0 && code < b_din1) begin
      r.tgt = T_DIN;  r.kind = K_S0;    r.idx = 8'(code - b_din0);
    end else if (code >= b_din1 && code < b_out0) begin
      r.tgt = T_DIN;  r.kind = K_S1;    r.idx = 8'(code - b_din1);
    end else if (code >= b_out0 && code < b_out1) begin
      r.tgt = T_DOUT; r.kind = K_S0;    r.idx = 8'(code - b_out0);
    end else if (code >= b_out1 && code < b_adr0) begin
      r.tgt = T_DOUT; r.kind = K_S1;    r.idx = 8'(code - b_out1);
    end else if (code >= b_adr0 && code < b_adr1) begin
      r.tgt = T_ADDR; r.kind = K_S0;    r.idx = 8'(code - b_adr0);
    end else if (code >= b_adr1 && code < b_dsh) begin
      r.tgt = T_ADDR; r.kind = K_S1;    r.idx = 8'(code - b_adr1);
    end else if (code >= b_dsh && code < b_osh) begin
      r.tgt = T_DIN;  r.kind = K_SHORT; r.idx = 8'(code - b_dsh);
    end else if (code >= b_osh && code < b_ash) begin
      r.tgt = T_DOUT; r.kind = K_SHORT; r.idx = 8'(code - b_osh);
    end else if (code >= b_ash && code < b_ctl) begin
      r.tgt = T_ADDR; r.kind = K_SHORT; r.idx = 8'(code - b_ash);
    end else if (code >= b_ctl && code < b_ctl + 3) begin
      r.tgt = T_CTL;  r.kind = K_S0;    r.idx = 8'(code - b_ctl);
    end
    return r;
  endfunction

endpackage

// File: rtl/sfm_path_fault.sv
module sfm_path_fault #(
  parameter int W = 8
) (
  input  logic          en,
  input  sfm_pkg::kind_e kind,
  input  logic [7:0]    idx,
  input  logic [W-1:0]  d_i,
  output logic [W-1:0]  d_o
);
  import sfm_pkg::*;

  logic [W:0] in_ext;
  logic [W:0] out_ext;
  assign in_ext  = {1'b1, d_i};
  assign out_ext = {1'b0, d_o};

  always_comb begin
    d_o = d_i;
    if (en) begin
      for (int b = 0; b < W; b++) begin
        if (int'(idx) == b) begin
          case (kind)
            K_S0:    d_o[b] = 1'b0;
            K_S1:    d_o[b] = 1'b1;
            K_SHORT: begin
              if (b < W - 1) begin
                d_o[b]   = in_ext[b] & in_ext[b+1];
                d_o[b+1] = in_ext[b] & in_ext[b+1];
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    for (int b = 0; b < W; b++) begin
      if (en && int'(idx) == b) begin
        if (kind == K_S0) begin
          // R4 R5 R6
          stuck_low_chk: assert (!d_o[b]);
        end else if (kind == K_S1) begin
          // R4 R5 R6
          stuck_high_chk: assert (d_o[b]);
        end else if (kind == K_SHORT && b < W - 1) begin
          // R7 R8 R9
          short_pair_chk: assert (out_ext[b] == out_ext[b+1] &&
                                  out_ext[b] == (in_ext[b] & in_ext[b+1]));
        end
      end
    end
  end

endmodule

// File: rtl/sfm_ctrl.sv
module sfm_ctrl (
  input  logic       en,
  input  logic [7:0] idx,
  input  logic       we_n,
  input  logic       oe_n,
  output logic       wr_en,
  output logic       rd_en
);
  import sfm_pkg::*;

  always_comb begin
    wr_en = !we_n;
    rd_en = !oe_n && we_n;
    if (en) begin
      case (idx)
        CTL_ALWAYS_WR: wr_en = 1'b1;
        CTL_NEVER_WR:  wr_en = 1'b0;
        CTL_NEVER_RD:  rd_en = 1'b0;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sfm_store.sv
module sfm_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // one port, read-first: the read sees the word before this edge's write
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
    if (rd_en) rdata <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= rd_en;
  end

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mem[$past(addr)] == $past(wdata));

  // R10
  read_first_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && wr_en) |=> rdata == $past(mem[addr]));

endmodule

// File: rtl/fault_sram.sv
module fault_sram #(
  parameter int DATA_W          = 8,
  parameter int ADDR_W          = 4,
  parameter int STUCK_ADDR_BITS = 2,
  parameter int SEL_W = sfm_pkg::sel_width(DATA_W, ADDR_W, STUCK_ADDR_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [SEL_W-1:0]  fault_sel,
  output logic [DATA_W-1:0] dout
);
  import sfm_pkg::*;

  localparam int CTL_BASE = ctl_base(DATA_W, ADDR_W, STUCK_ADDR_BITS);
  localparam logic [SEL_W-1:0] NO_READ_CODE = SEL_W'(CTL_BASE + 2);

  fault_t            flt;
  logic [DATA_W-1:0] din_eff;
  logic [ADDR_W-1:0] addr_eff;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] dout_raw;
  logic              wr_en, rd_en, rvalid;

  always_comb flt = decode_fault(int'(fault_sel), DATA_W, ADDR_W, STUCK_ADDR_BITS);

  sfm_path_fault #(.W(DATA_W)) u_din_fault (
    .en(flt.tgt == T_DIN), .kind(flt.kind), .idx(flt.idx),
    .d_i(din), .d_o(din_eff)
  );

  sfm_path_fault #(.W(ADDR_W)) u_addr_fault (
    .en(flt.tgt == T_ADDR), .kind(flt.kind), .idx(flt.idx),
    .d_i(addr), .d_o(addr_eff)
  );

  sfm_ctrl u_ctrl (
    .en(flt.tgt == T_CTL), .idx(flt.idx),
    .we_n(we_n), .oe_n(oe_n),
    .wr_en(wr_en), .rd_en(rd_en)
  );

  sfm_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr_eff), .wdata(din_eff),
    .rdata(rd_word), .rvalid(rvalid)
  );

  assign dout_raw = rvalid ? rd_word : '0;

  sfm_path_fault #(.W(DATA_W)) u_dout_fault (
    .en(flt.tgt == T_DOUT), .kind(flt.kind), .idx(flt.idx),
    .d_i(dout_raw), .d_o(dout)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst) && fault_sel == '0) |-> dout == '0);

  // R3
  read_off_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_sel == '0 && (oe_n || !we_n)) ##1 (fault_sel == '0) |-> dout == '0);

  // R12
  no_read_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_sel == NO_READ_CODE) ##1 (fault_sel == NO_READ_CODE) |-> dout == '0);

endmodule

// File: tb/tb_fault_sram.sv
`timescale 1ns/1ps
module tb_fault_sram;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       we_n = 1'b1;
  logic       oe_n = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] din = '0;
  logic [5:0] fault_sel = '0;
  logic [7:0] dout;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] mdl [16];

  always #2 clk = ~clk;

  fault_sram dut (
    .clk(clk), .rst(rst), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .fault_sel(fault_sel), .dout(dout)
  );

  function automatic logic [7:0] short8(logic [7:0] v, int k);
    logic b;
    b = v[k] & v[k+1];
    v[k] = b;
    v[k+1] = b;
    return v;
  endfunction

  function automatic logic [7:0] in_map(logic [7:0] v, int f);
    if (f >= 1 && f <= 8)   v[f-1] = 1'b0;
    if (f >= 9 && f <= 16)  v[f-9] = 1'b1;
    if (f >= 37 && f <= 43) v = short8(v, f - 37);
    return v;
  endfunction

  function automatic logic [7:0] out_map(logic [7:0] v, int f);
    if (f >= 17 && f <= 24) v[f-17] = 1'b0;
    if (f >= 25 && f <= 32) v[f-25] = 1'b1;
    if (f >= 44 && f <= 50) v = short8(v, f - 44);
    return v;
  endfunction

  function automatic logic [3:0] adr_map(logic [3:0] a, int f);
    logic b;
    if (f >= 33 && f <= 34) a[f-33] = 1'b0;
    if (f >= 35 && f <= 36) a[f-35] = 1'b1;
    if (f >= 51 && f <= 53) begin
      b = a[f-51] & a[f-50];
      a[f-51] = b;
      a[f-50] = b;
    end
    return a;
  endfunction

  function automatic string lbl(int f);
    if (f == 0)  return "R2";
    if (f <= 16) return "R4";
    if (f <= 32) return "R5";
    if (f <= 36) return "R6";
    if (f <= 43) return "R7";
    if (f <= 50) return "R8";
    if (f <= 53) return "R9";
    if (f == 54) return "R10";
    if (f == 55) return "R11";
    if (f == 56) return "R12";
    return "R13";
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: dout=%02h expected %02h (fault %0d)", tag, got, exp, fault_sel);
    end
  endtask

  // one cycle; starts and ends on a falling edge
  task automatic step(logic w, logic o, logic [3:0] a, logic [7:0] d, int f, string tag);
    logic [3:0] ae;
    logic wr, rd;
    logic [7:0] exp;
    ae  = adr_map(a, f);
    wr  = (f == 54) || (!w && f != 55);
    rd  = !o && w && f != 56;
    exp = out_map(rd ? mdl[ae] : 8'h00, f);
    if (wr) mdl[ae] = in_map(d, f);
    we_n = w; oe_n = o; addr = a; din = d; fault_sel = 6'(f);
    @(posedge clk);
    @(negedge clk);
    check(tag, dout, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: idle output right after reset
    check("R1", dout, 8'h00);
    for (int f = 0; f < 64; f++) begin
      // fill every word under fault code 0
      for (int a = 0; a < 16; a++)
        step(1'b0, 1'b1, 4'(a), 8'((a * 29 + f * 7) ^ 8'h5A), 0, "R2");
      // write pass with the fault applied
      for (int a = 0; a < 16; a++)
        step(1'b0, 1'b1, 4'(a), 8'((a * 53 + f * 13) ^ 8'hA5), f, lbl(f));
      // read pass, fresh din each cycle (R10 collisions)
      for (int a = 0; a < 16; a++)
        step(1'b1, 1'b0, 4'(a), 8'(~(a * 3 + f)), f, lbl(f));
      // idle cycle: R3 when fault-free, R5/R8 when the bus is faulted
      step(1'b1, 1'b1, 4'(f % 16), 8'h3C, f, (f == 0) ? "R3" : lbl(f));
      // read strobe with write strobe also low: no read (R3)
      step(1'b0, 1'b0, 4'(f % 16), 8'hC3, f, (f == 0) ? "R3" : lbl(f));
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule